// File: doc/BRIEF.md
# Inline Memory Upload Engine

This block sits behind a command stream that delivers method writes, each one a register index paired with a 32-bit value. Every legal write lands in a small register file. Some of those registers describe a destination: a 64-bit byte base address split into high and low halves, plus offset fields. Two registers have side effects. A write to the launch register rewinds an internal word cursor. Each write to the data register becomes one 32-bit memory store at the base address plus four bytes per cursor step, and the cursor then advances by one.

Memory stores leave through a single-entry request port with a valid/ready handshake. While a store waits for acceptance, the command port lowers its ready signal. Data words are therefore never dropped and never reordered. Two sticky flags report problems. The first reports a write whose index falls outside the register file. The second reports a data write made while the layout is not linear or while any of the x, y or z offsets is non-zero. Any register can be read back combinationally by index.

Top module: `inline_upload_engine`

## Requirements
- R1: After reset every register reads back zero, the cursor is zero, both error flags are low, no memory request is pending and `cmd_ready` is high.
- R2: An accepted write with index below 0x7F stores its value, and the next read of that index on `rd_index` returns it. Reading an index of 0x7F or above returns zero.
- R3: An accepted write with index 0x7F or above changes no register, including index (value mod 128), and sets `err_bad_index`.
- R4: A write to index 0x6C (launch) stores its value and sets the word cursor to zero. Bit 0 of the stored launch value selects the linear layout.
- R5: A write to index 0x6D (data) is supported when launch bit 0 is 1 and registers 0x69 (z), 0x6A (x) and 0x6B (y) are all zero. In that case it raises one memory request with address {reg 0x62, reg 0x63} + 4 × cursor and data equal to the written value, and the cursor increments.
- R6: A data write in any other configuration raises no memory request, leaves the cursor unchanged, still stores the value at 0x6D and sets `err_unsupported`.
- R7: A pending request keeps `mem_req_valid`, `mem_req_addr` and `mem_req_data` stable until `mem_req_ready` is seen. While a request is pending, `cmd_ready` is low.
- R8: The address sum is a full 64-bit add, so a carry from the low word propagates into the high word.
- R9: Both error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Method write present |
| cmd_ready | output | 1 | Method write can be accepted |
| cmd_index | input | 8 | Register index of the method write |
| cmd_value | input | 32 | Value of the method write |
| rd_index | input | 8 | Readback index |
| rd_value | output | 32 | Register contents at `rd_index`, zero when out of range |
| mem_req_valid | output | 1 | Memory store request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the store |
| mem_req_data | output | 32 | Word to store |
| err_bad_index | output | 1 | Sticky: out-of-range method index seen |
| err_unsupported | output | 1 | Sticky: data write in an unsupported layout |

## Verification
A wrong cursor stays hidden until the next accepted store, where it appears at the port as an address off by a multiple of four. A cursor that was not rewound shows up on the first store after a launch. A corrupted or aliased register appears on the readback port in the same cycle it is selected. A wrong layout decision shows up one cycle after the data write, either as an unexpected request or as a wrong error flag. The bench models the registers, cursor and flags on every clock, so each of these faults surfaces at the first handshake or readback that depends on it. Memory stalls are included so that a request dropped or changed while waiting is caught.

// File: rtl/upl_pkg.sv
package upl_pkg;

   // Register indices whose position the block decodes
   localparam int unsigned UPL_REG_DST_HI = 'h62;
   localparam int unsigned UPL_REG_DST_LO = 'h63;
   localparam int unsigned UPL_REG_DST_Z  = 'h69;
   localparam int unsigned UPL_REG_DST_X  = 'h6A;
   localparam int unsigned UPL_REG_DST_Y  = 'h6B;
   localparam int unsigned UPL_REG_LAUNCH = 'h6C;
   localparam int unsigned UPL_REG_DATA   = 'h6D;

   // Bit of the launch register selecting the linear layout
   localparam int unsigned UPL_LINEAR_BIT = 0;

   typedef enum logic [1:0] {
      CMD_STORE,
      CMD_LAUNCH,
      CMD_DATA,
      CMD_ILLEGAL
   } upl_cmd_e;

endpackage

// File: rtl/upl_decode.sv
module upl_decode
   import upl_pkg::*;
#(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned NUM_REGS = 127
) (
   input  logic [IDX_W-1:0] idx,
   output upl_cmd_e         kind
);

   always_comb begin
      if (32'(idx) >= NUM_REGS) begin
         kind = CMD_ILLEGAL;
      end else if (idx == IDX_W'(UPL_REG_LAUNCH)) begin
         kind = CMD_LAUNCH;
      end else if (idx == IDX_W'(UPL_REG_DATA)) begin
         kind = CMD_DATA;
      end else begin
         kind = CMD_STORE;
      end
   end

endmodule

// File: rtl/upl_regfile.sv
module upl_regfile
   import upl_pkg::*;
#(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_val,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] tap_hi,
   output logic [DATA_W-1:0] tap_lo,
   output logic [DATA_W-1:0] tap_x,
   output logic [DATA_W-1:0] tap_y,
   output logic [DATA_W-1:0] tap_z,
   output logic              tap_linear
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NUM_REGS); i++) begin
            mem[i] <= '0;
         end
      end else if (wr_en) begin
         for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (wr_idx == IDX_W'(i)) begin
               mem[i] <= wr_val;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_data = mem[i];
         end
      end
   end

   assign tap_hi     = mem[UPL_REG_DST_HI];
   assign tap_lo     = mem[UPL_REG_DST_LO];
   assign tap_x      = mem[UPL_REG_DST_X];
   assign tap_y      = mem[UPL_REG_DST_Y];
   assign tap_z      = mem[UPL_REG_DST_Z];
   assign tap_linear = mem[UPL_REG_LAUNCH][UPL_LINEAR_BIT];

   // R2
   store_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(UPL_REG_DST_X)) |=> (tap_x == $past(wr_val)));

   // R4
   store_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(UPL_REG_LAUNCH)) |=> (tap_linear == $past(wr_val[UPL_LINEAR_BIT])));

endmodule

// File: rtl/upl_cursor.sv
module upl_cursor #(
   parameter int unsigned CUR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CUR_W-1:0] cursor
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cursor <= '0;
      end else if (clr) begin
         cursor <= '0;
      end else if (inc) begin
         cursor <= cursor + CUR_W'(1);
      end
   end

   // R4
   launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cursor == '0));

   // R5
   cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (cursor == $past(cursor) + CUR_W'(1)));

endmodule

// File: rtl/upl_req_gen.sv
module upl_req_gen #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CUR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] base,
   input  logic [CUR_W-1:0]  cursor,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ready,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned WORD_SHIFT = $clog2(WORD_BYTES);

   logic [ADDR_W-1:0] offset;

   // Cursor is widened to the address width, or cut when wider
   if (CUR_W < ADDR_W) begin : g_ext
      assign offset = {{(ADDR_W-CUR_W){1'b0}}, cursor} << WORD_SHIFT;
   end else begin : g_cut
      assign offset = cursor[ADDR_W-1:0] << WORD_SHIFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
      end else if (issue) begin
         valid <= 1'b1;
         addr  <= base + offset;
         data  <= wdata;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));

   // R7
   no_issue_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !valid);

endmodule

// File: rtl/inline_upload_engine.sv
module inline_upload_engine
   import upl_pkg::*;
#(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned CUR_W    = 32,
   parameter int unsigned NUM_REGS = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [IDX_W-1:0]  cmd_index,
   input  logic [WORD_W-1:0] cmd_value,
   input  logic [IDX_W-1:0]  rd_index,
   output logic [WORD_W-1:0] rd_value,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [WORD_W-1:0] mem_req_data,
   output logic              err_bad_index,
   output logic              err_unsupported
);

   // Elaboration-time parameter checks
   if (ADDR_W != 2 * WORD_W) begin : g_bad_addr_w
      $error("ADDR_W must be twice WORD_W");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word_w
      $error("WORD_W must be a whole number of bytes");
   end
   if (NUM_REGS <= UPL_REG_DATA) begin : g_bad_depth
      $error("NUM_REGS must cover the data register");
   end
   if (NUM_REGS > (1 << IDX_W)) begin : g_bad_idx_w
      $error("IDX_W too narrow for NUM_REGS");
   end
   if (CUR_W > ADDR_W) begin : g_bad_cur_w
      $error("CUR_W must not exceed ADDR_W");
   end

   upl_cmd_e          kind;
   logic              accept;
   logic              mode_ok;
   logic              do_issue;
   logic              do_reject;
   logic [WORD_W-1:0] dst_hi, dst_lo, dst_x, dst_y, dst_z;
   logic              linear;
   logic [CUR_W-1:0]  cursor;

   assign cmd_ready = !mem_req_valid;
   assign accept    = cmd_valid && cmd_ready;

   upl_decode #(
      .IDX_W    (IDX_W),
      .NUM_REGS (NUM_REGS)
   ) decode_i (
      .idx  (cmd_index),
      .kind (kind)
   );

   upl_regfile #(
      .IDX_W    (IDX_W),
      .DATA_W   (WORD_W),
      .NUM_REGS (NUM_REGS)
   ) regfile_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (accept && kind != CMD_ILLEGAL),
      .wr_idx     (cmd_index),
      .wr_val     (cmd_value),
      .rd_idx     (rd_index),
      .rd_data    (rd_value),
      .tap_hi     (dst_hi),
      .tap_lo     (dst_lo),
      .tap_x      (dst_x),
      .tap_y      (dst_y),
      .tap_z      (dst_z),
      .tap_linear (linear)
   );

   assign mode_ok   = linear && (dst_x == '0) && (dst_y == '0) && (dst_z == '0);
   assign do_issue  = accept && (kind == CMD_DATA) && mode_ok;
   assign do_reject = accept && (kind == CMD_DATA) && !mode_ok;

   upl_cursor #(
      .CUR_W (CUR_W)
   ) cursor_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept && kind == CMD_LAUNCH),
      .inc    (do_issue),
      .cursor (cursor)
   );

   upl_req_gen #(
      .ADDR_W (ADDR_W),
      .DATA_W (WORD_W),
      .CUR_W  (CUR_W)
   ) req_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue  (do_issue),
      .base   ({dst_hi, dst_lo}),
      .cursor (cursor),
      .wdata  (cmd_value),
      .ready  (mem_req_ready),
      .valid  (mem_req_valid),
      .addr   (mem_req_addr),
      .data   (mem_req_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_bad_index   <= 1'b0;
         err_unsupported <= 1'b0;
      end else begin
         if (accept && kind == CMD_ILLEGAL) begin
            err_bad_index <= 1'b1;
         end
         if (do_reject) begin
            err_unsupported <= 1'b1;
         end
      end
   end

   // R3
   bad_index_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && 32'(cmd_index) >= NUM_REGS) |=> err_bad_index);

   // R6
   reject_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_reject |=> (!mem_req_valid && err_unsupported));

   // R9
   bad_index_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_index |=> err_bad_index);

   // R9
   unsupported_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_unsupported |=> err_unsupported);

endmodule

// File: tb/inline_upload_engine_tb.sv
`timescale 1ns/1ps
module inline_upload_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [7:0]  cmd_index = '0;
   logic [31:0] cmd_value = '0;
   logic [7:0]  rd_index = '0;
   logic [31:0] rd_value;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [63:0] mem_req_addr;
   logic [31:0] mem_req_data;
   logic        err_bad_index;
   logic        err_unsupported;

   inline_upload_engine dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_valid       (cmd_valid),
      .cmd_ready       (cmd_ready),
      .cmd_index       (cmd_index),
      .cmd_value       (cmd_value),
      .rd_index        (rd_index),
      .rd_value        (rd_value),
      .mem_req_valid   (mem_req_valid),
      .mem_req_ready   (mem_req_ready),
      .mem_req_addr    (mem_req_addr),
      .mem_req_data    (mem_req_data),
      .err_bad_index   (err_bad_index),
      .err_unsupported (err_unsupported)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference model state
   logic [31:0] m_regs [0:126];
   int unsigned m_cursor;
   bit          m_err_bad;
   bit          m_err_uns;
   logic [63:0] exp_addr_q [$];
   logic [31:0] exp_data_q [$];

   bit          stall_on = 1'b0;
   int          cyc = 0;
   bit          prev_stall = 1'b0;
   logic [63:0] prev_addr;
   logic [31:0] prev_data;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 127; i++) m_regs[i] = '0;
      m_cursor  = 0;
      m_err_bad = 1'b0;
      m_err_uns = 1'b0;
      exp_addr_q.delete();
      exp_data_q.delete();
   endtask

   task automatic model_apply(input int idx, input logic [31:0] val);
      if (idx >= 127) begin
         m_err_bad = 1'b1;
      end else begin
         m_regs[idx] = val;
         if (idx == 'h6C) m_cursor = 0;
         if (idx == 'h6D) begin
            if (m_regs['h6C][0] && m_regs['h69] == 0 && m_regs['h6A] == 0 && m_regs['h6B] == 0) begin
               exp_addr_q.push_back({m_regs['h62], m_regs['h63]} + 64'(m_cursor) * 64'd4);
               exp_data_q.push_back(val);
               m_cursor++;
            end else begin
               m_err_uns = 1'b1;
            end
         end
      end
   endtask

   // Called at a falling edge; returns at a falling edge
   task automatic put(input int idx, input logic [31:0] val);
      cmd_valid = 1'b1;
      cmd_index = 8'(idx);
      cmd_value = val;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      model_apply(idx, val);
   endtask

   task automatic rb(input int idx, input logic [31:0] exp, input string req);
      rd_index = 8'(idx);
      #0.1;
      chk(rd_value === exp, req, 64'(rd_value), 64'(exp));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic drain();
      repeat (12) @(negedge clk);
      chk(exp_addr_q.size() == 0, "R5 queue drained", 64'(exp_addr_q.size()), 64'd0);
   endtask

   // Memory-side ready pattern
   always @(negedge clk) begin
      cyc++;
      mem_req_ready = stall_on ? (cyc % 3 == 0) : 1'b1;
   end

   // Per-clock comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(err_bad_index === m_err_bad, "R3 R9 err_bad_index", 64'(err_bad_index), 64'(m_err_bad));
         chk(err_unsupported === m_err_uns, "R6 R9 err_unsupported", 64'(err_unsupported), 64'(m_err_uns));
         if (mem_req_valid) chk(!cmd_ready, "R7 cmd_ready while pending", 64'(cmd_ready), 64'd0);
         if (prev_stall) begin
            chk(mem_req_valid === 1'b1, "R7 valid held", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr === prev_addr, "R7 addr held", mem_req_addr, prev_addr);
            chk(mem_req_data === prev_data, "R7 data held", 64'(mem_req_data), 64'(prev_data));
         end
         if (mem_req_valid && mem_req_ready) begin
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R5 R6 unexpected request", mem_req_addr, 64'd0);
            end else begin
               logic [63:0] ea;
               logic [31:0] ed;
               ea = exp_addr_q.pop_front();
               ed = exp_data_q.pop_front();
               chk(mem_req_addr === ea, "R5 R8 request address", mem_req_addr, ea);
               chk(mem_req_data === ed, "R5 request data", 64'(mem_req_data), 64'(ed));
            end
         end
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         prev_data  = mem_req_data;
      end else begin
         prev_stall = 1'b0;
      end
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R1 reset state
      chk(cmd_ready === 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
      chk(mem_req_valid === 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk(err_bad_index === 1'b0 && err_unsupported === 1'b0, "R1 flags",
          {err_bad_index, err_unsupported}, 64'd0);
      for (int i = 0; i < 127; i++) rb(i, 32'h0, "R1 register zero");
      @(negedge clk);

      // R2 plain store and readback
      put('h60, 32'h0000_0040);
      put('h61, 32'h0000_0001);
      put('h05, 32'hCAFE_0005);
      rb('h60, 32'h0000_0040, "R2 line length");
      rb('h61, 32'h0000_0001, "R2 line count");
      rb('h05, 32'hCAFE_0005, "R2 low index");
      rb('h7F, 32'h0, "R2 readback out of range");
      rb('hC0, 32'h0, "R2 readback far out of range");
      @(negedge clk);

      // R5 R8 linear stream across a 32-bit address carry, with memory stalls
      put('h62, 32'h0000_0001);
      put('h63, 32'hFFFF_FFF8);
      put('h6C, 32'h0000_0001);
      rb('h6C, 32'h1, "R4 launch stored");
      @(negedge clk);
      stall_on = 1'b1;
      put('h6D, 32'hA000_0000);
      put('h6D, 32'hA000_0001);
      put('h6D, 32'hA000_0002);
      put('h6D, 32'hA000_0003);
      drain();
      stall_on = 1'b0;

      // R4 relaunch rewinds cursor
      put('h6C, 32'h0000_0001);
      put('h6D, 32'hB000_0000);
      put('h6D, 32'hB000_0001);
      drain();

      // R6 non-zero x offset rejects, cursor held, value still stored
      put('h6A, 32'h0000_0005);
      put('h6D, 32'hC000_0000);
      rb('h6D, 32'hC000_0000, "R6 data stored on reject");
      repeat (3) @(negedge clk);
      chk(mem_req_valid === 1'b0, "R6 no request on reject", 64'(mem_req_valid), 64'd0);
      put('h6A, 32'h0000_0000);
      put('h6D, 32'hC000_0001);
      drain();
      chk(err_unsupported === 1'b1, "R9 unsupported stays set", 64'(err_unsupported), 64'd1);

      // R3 out-of-range writes, including aliases of index 0 and 0x7F-1
      put('h80, 32'hDEAD_0000);
      put('hFE, 32'hDEAD_007E);
      put('h7F, 32'hDEAD_007F);
      rb('h00, 32'h0, "R3 no alias to index 0");
      rb('h7E, 32'h0, "R3 no alias to index 0x7E");
      @(negedge clk);
      chk(err_bad_index === 1'b1, "R3 flag set", 64'(err_bad_index), 64'd1);

      // R9 reset clears flags; R6 non-zero z offset
      do_reset();
      chk(err_bad_index === 1'b0 && err_unsupported === 1'b0, "R9 flags cleared by reset",
          {err_bad_index, err_unsupported}, 64'd0);
      put('h69, 32'h0000_0002);
      put('h6C, 32'h0000_0001);
      put('h6D, 32'hD000_0000);
      drain();

      // R6 non-zero y offset
      do_reset();
      put('h6B, 32'h0000_0001);
      put('h6C, 32'h0000_0001);
      put('h6D, 32'hD100_0000);
      drain();

      // R6 non-linear launch, then R4 linear bit only matters: value 0x3 is linear
      do_reset();
      put('h6C, 32'h0000_0002);
      put('h6D, 32'hE000_0000);
      drain();
      put('h62, 32'h0000_0000);
      put('h63, 32'h0000_1000);
      put('h6C, 32'h0000_0003);
      put('h6D, 32'hE000_0001);
      put('h6D, 32'hE000_0002);
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule